// File: doc/BRIEF.md
# Edge-Triggered Programmable Interval Timer

This block is a small register-mapped timer. A 16-bit divider advances once for every clock in which the machine-cycle `tick` input is high. Software can read the upper byte of the divider. A write of any value to the divider clears all sixteen bits. An 8-bit counter advances on every high-to-low transition of a gated signal. That signal is the enable bit of the control register ANDed with one divider bit, and a 2-bit select field chooses which bit.

When the counter steps past its maximum value, it takes its next value from a modulo register. In the same step the block raises a one-clock interrupt request, which an interrupt-flag register outside the block latches.

The counter advances on an edge of the gated signal, not on a prescaler count. Any event that pulls the gated signal low therefore counts as a step. Such events are clearing the divider while the selected bit is high, clearing the enable bit, and changing the select field.

Top module: `prog_interval_timer`

## Requirements
- R1: While `tick` is high and no divider write occurs, the divider increases by one per clock and wraps from 0xFFFF to 0x0000. While `tick` is low, it holds its value.
- R2: A read at address 0 returns bits 15:8 of the divider.
- R3: A write at address 0 clears the whole divider to zero, whatever the write data.
- R4: Control bit 2 enables the gate. Control bits 1:0 pick the divider bit: 00 picks bit 9, 01 picks bit 3, 10 picks bit 5 and 11 picks bit 7. With bit 3 picked and counting from a cleared divider, the counter advances once every 16 ticks.
- R5: The counter advances by one only in the clock after the gated signal goes from 1 to 0. This includes a fall caused by a divider clear or by clearing the enable bit, and each such fall gives exactly one step.
- R6: A step taken from 0xFF loads the modulo register value into the counter. In the same clock, `irq` goes high for exactly one cycle.
- R7: A write at address 1 loads the counter at once, and it takes precedence over a step that falls in the same clock.
- R8: A write at address 2 sets the modulo register at once. Address 3 reads back control bits 2:0, with bits 7:3 reading as 1.
- R9: After reset, the divider, counter, modulo and control registers are all zero and `irq` is low. Address 3 therefore reads 0xF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Machine-cycle advance for the divider |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 divider, 1 counter, 2 modulo, 3 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | One-cycle timer interrupt request |

## Verification
A wrong divider value shows up in two ways. It changes the divider byte read at address 0 within one clock. It also moves the clock in which the counter steps, so the counter read at address 1 differs by the time the selected bit next falls. A stale or missing previous-gate flop shows up one clock after a divider clear or an enable clear: the counter either fails to step or steps twice. A reload fault is visible in the single clock after an overflow, as a wrong counter value or an `irq` that is missing or lasts two cycles.

// File: rtl/prog_interval_timer.sv
module prog_interval_timer #(
  parameter int DIV_W = 16,
  parameter int CNT_W = 8,
  parameter int TAP0  = 9,
  parameter int TAP1  = 3,
  parameter int TAP2  = 5,
  parameter int TAP3  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             irq
);
  localparam logic [1:0] A_DIV = 2'd0;
  localparam logic [1:0] A_CNT = 2'd1;
  localparam logic [1:0] A_MOD = 2'd2;
  localparam logic [1:0] A_CTL = 2'd3;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q, mod_q;
  logic [2:0]       ctl_q;
  logic             gate_q, tap, gate, fall;
  logic             wr_div, wr_cnt;

  assign wr_div = wr_en && addr == A_DIV;
  assign wr_cnt = wr_en && addr == A_CNT;

  always_comb begin
    case (ctl_q[1:0])
      2'b00:   tap = div_q[TAP0];
      2'b01:   tap = div_q[TAP1];
      2'b10:   tap = div_q[TAP2];
      default: tap = div_q[TAP3];
    endcase
  end

  assign gate = ctl_q[2] & tap;
  assign fall = gate_q & ~gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate;
      if (wr_div)    div_q <= '0;
      else if (tick) div_q <= div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (wr_cnt) cnt_q <= wdata;
      else if (fall) begin
        if (cnt_q == CNT_MAX) begin
          cnt_q <= mod_q;
          irq   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q <= '0;
      ctl_q <= '0;
    end else if (wr_en) begin
      if (addr == A_MOD) mod_q <= wdata;
      if (addr == A_CTL) ctl_q <= wdata[2:0];
    end
  end

  always_comb begin
    case (addr)
      A_DIV:   rdata = div_q[DIV_W-1 -: CNT_W];
      A_CNT:   rdata = cnt_q;
      A_MOD:   rdata = mod_q;
      default: rdata = {{(CNT_W-3){1'b1}}, ctl_q};
    endcase
  end

  a_r3_div_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_div |=> div_q == '0);

  a_r1_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_div) |=> $stable(div_q));

  a_r5_step_only_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && !wr_cnt) |=> $stable(cnt_q));

  a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cnt_q == $past(mod_q));

  a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_q == $past(wdata) && !irq));
endmodule

// File: tb/prog_interval_timer_bench.sv
module prog_interval_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0, rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [15:0] m_div;
  logic [7:0]  m_cnt, m_mod;
  logic [2:0]  m_ctl;
  logic        m_prev, m_irq;

  always #5 clk = ~clk;

  prog_interval_timer u_prog_interval_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_div[15:8];
      2'd1: return m_cnt;
      2'd2: return m_mod;
      default: return {5'h1F, m_ctl};
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [1:0] a, input logic [7:0] wd,
                      input logic tk, input string req);
    logic tp, g, f;
    @(negedge clk);
    wr_en = we; addr = a; wdata = wd; tick = tk;
    case (m_ctl[1:0])
      2'b00: tp = m_div[9];
      2'b01: tp = m_div[3];
      2'b10: tp = m_div[5];
      default: tp = m_div[7];
    endcase
    g = m_ctl[2] & tp;
    f = m_prev & ~g;
    m_prev = g;
    m_irq = 1'b0;
    if (we && a == 2'd1) m_cnt = wd;
    else if (f) begin
      if (m_cnt == 8'hFF) begin m_cnt = m_mod; m_irq = 1'b1; end
      else m_cnt = m_cnt + 8'd1;
    end
    if (we && a == 2'd0) m_div = 16'd0;
    else if (tk) m_div = m_div + 16'd1;
    if (we && a == 2'd2) m_mod = wd;
    if (we && a == 2'd3) m_ctl = wd[2:0];
    @(posedge clk); #1;
    check({req, " rdata"}, rdata, m_read(a));
    check({req, " irq"}, {7'd0, irq}, {7'd0, m_irq});
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string req);
    step(1'b1, a, d, 1'b0, req);
  endtask

  task automatic idle(input logic [1:0] a, input string req);
    step(1'b0, a, 8'd0, 1'b0, req);
  endtask

  task automatic run(input int n, input logic [1:0] a, input string req);
    for (int i = 0; i < n; i++) step(1'b0, a, 8'd0, 1'b1, req);
  endtask

  task automatic peek(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0; addr = a;
    #1 check(req, rdata, exp);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] base;
    m_div = 0; m_cnt = 0; m_mod = 0; m_ctl = 0; m_prev = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R9 reset state
    peek(2'd0, 8'h00, "R9 divider");
    peek(2'd1, 8'h00, "R9 counter");
    peek(2'd2, 8'h00, "R9 modulo");
    peek(2'd3, 8'hF8, "R9 control");
    check("R9 irq", {7'd0, irq}, 8'd0);

    // R1 R2 full divider wrap, R8 control readback
    run(65536 + 300, 2'd0, "R1 R2 divider");
    run(5, 2'd3, "R8 control");
    for (int i = 0; i < 5; i++) idle(2'd0, "R1 hold");

    // R3 clear with arbitrary data
    wr(2'd0, 8'hA5, "R3 clear");
    peek(2'd0, 8'h00, "R3 divider zero");

    // R4 R6 sweep every select with overflows
    for (int s = 0; s < 4; s++) begin
      wr(2'd3, 8'h00, "R4 disable");
      wr(2'd0, 8'h00, "R3 clear");
      wr(2'd2, 8'hF0 + 8'(s), "R8 modulo");
      wr(2'd1, 8'hFD, "R7 preset");
      wr(2'd3, 8'h04 | 8'(s), "R4 select");
      run(s == 0 ? 7000 : 2200, 2'd1, "R4 R6 sweep");
    end

    // R4 arithmetic rate for select 01
    wr(2'd3, 8'h00, "R4 disable");
    wr(2'd0, 8'h00, "R3 clear");
    wr(2'd1, 8'h00, "R7 zero");
    wr(2'd3, 8'h05, "R4 enable sel01");
    run(200, 2'd1, "R4 rate");
    peek(2'd1, 8'd12, "R4 200 ticks give 12 steps");

    // R5 divider clear with bit 3 high gives one step
    wr(2'd3, 8'h00, "R4 disable");
    wr(2'd0, 8'h00, "R3 clear");
    wr(2'd1, 8'h20, "R7 load");
    wr(2'd3, 8'h05, "R4 enable");
    run(9, 2'd1, "R5 raise tap");
    wr(2'd0, 8'h00, "R5 clear while high");
    idle(2'd1, "R5 after clear");
    idle(2'd1, "R5 settle");
    peek(2'd1, 8'h21, "R5 clear step");

    // R5 enable clear with bit 3 high gives one step
    run(9, 2'd1, "R5 raise tap");
    wr(2'd3, 8'h01, "R5 disable while high");
    idle(2'd1, "R5 after disable");
    idle(2'd1, "R5 settle");
    peek(2'd1, 8'h22, "R5 disable step");
    run(40, 2'd1, "R5 disabled no steps");
    peek(2'd1, 8'h22, "R5 no step while disabled");

    // R7 write wins over coincident step
    wr(2'd0, 8'h00, "R3 clear");
    wr(2'd3, 8'h05, "R4 enable");
    wr(2'd1, 8'h10, "R7 load");
    run(16, 2'd1, "R7 approach");
    step(1'b1, 2'd1, 8'h40, 1'b1, "R7 collide");
    peek(2'd1, 8'h40, "R7 write wins");

    // R6 overflow and single-cycle irq at known cycle
    wr(2'd3, 8'h00, "R4 disable");
    wr(2'd0, 8'h00, "R3 clear");
    wr(2'd2, 8'h30, "R8 modulo");
    wr(2'd1, 8'hFE, "R7 preset");
    wr(2'd3, 8'h05, "R4 enable");
    run(33, 2'd1, "R6 approach");
    check("R6 irq high after overflow", {7'd0, irq}, 8'd1);
    peek(2'd1, 8'h30, "R6 reload");
    run(1, 2'd1, "R6 next");
    check("R6 irq one cycle", {7'd0, irq}, 8'd0);
    base = 8'h30;
    peek(2'd2, base, "R8 modulo held");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule